// File: doc/BRIEF.md
# Run/Single-Step Clock-Enable Generator

This block sits beside a small processor system that runs from one free-running system clock of about 2 MHz. The clock itself is never stopped or swapped. Instead, the block produces a clock-enable for the CPU and bus logic. A mode switch picks one of two behaviours. In run mode the enable is held high on every cycle. In step mode a press of a push-button advances the enabled logic by exactly one system-clock cycle. Peripherals that need continuous timing stay on the ungated clock and never see this enable.

The raw button and the mode switch are asynchronous to the clock, so both first pass through a two-stage synchronizer. The synchronized button is then debounced: it must hold a new level for a configurable number of clocks (20 ms of system clock by default) before that level is accepted. A rising edge of the debounced level is turned into a single enable pulse one clock wide. The debounced level is also brought out, but only so that it can be observed.

Top module: `step_enable_gen`

## Requirements
- R1: While `rst_n` is low, and on the first clock edge that samples it low, `cpu_en` and `btn_level` are driven low and the debounce count is cleared.
- R2: `btn_raw` and `mode_run` each pass through two synchronizing flip-flops. A change of `mode_run` reaches `cpu_en` on the third rising clock edge after it, and not earlier.
- R3: `btn_level` takes a new value only after the synchronized button has differed from it on DEBOUNCE_CYCLES consecutive clock edges. A clean change of `btn_raw` shows on `btn_level` after exactly DEBOUNCE_CYCLES + 2 edges.
- R4: A button excursion that lasts fewer than DEBOUNCE_CYCLES clocks is ignored. `btn_level` does not change and no enable pulse appears.
- R5: In step mode (`mode_run` = 0), each rising edge of `btn_level` produces `cpu_en` = 1 for exactly one clock cycle, one cycle after `btn_level` rises.
- R6: Holding the button produces only one pulse. Releasing it produces none, so a further pulse needs a release followed by a new press.
- R7: In run mode (`mode_run` = 1), `cpu_en` is 1 on every cycle once the synchronized mode is seen.
- R8: A mode change never creates an extra pulse. A press that completes while in run mode gives no pulse after a return to step mode, and going from step to run only makes `cpu_en` steadily high.
- R9: In step mode with no press, `cpu_en` stays low for any length of time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Synchronous reset, active low |
| btn_raw | input | 1 | Raw, bouncing, asynchronous push-button (1 = pressed) |
| mode_run | input | 1 | Asynchronous mode switch: 1 = free-run, 0 = single-step |
| cpu_en | output | 1 | Clock-enable for the CPU and bus logic |
| btn_level | output | 1 | Debounced button level, for observation only |

## Verification
The assertions assume that `rst_n` is applied for at least one clock edge before any check matters. They also assume that the inputs are sampled only through the synchronizers, so a change of `btn_raw` or `mode_run` is never expected to appear inside the same cycle. The stimulus changes every input on the falling clock edge, holds presses well past the debounce window, and keeps bounces deliberately one clock short of it. The behavioural model therefore sees the same edge-aligned values as the design.

// File: rtl/step_en_pkg.sv
// Package: shared types and helpers for the run/single-step enable generator.
// Assumes: nothing beyond a standard elaborator.
package step_en_pkg;

    // Operating mode as seen after synchronization.
    typedef enum logic {
        MODE_STEP = 1'b0,
        MODE_RUN  = 1'b1
    } mode_e;

    // Number of clocks in the debounce window, never less than one.
    function automatic int unsigned window_cycles(input int unsigned clk_hz,
                                                  input int unsigned win_ms);
        int unsigned n;
        n = (clk_hz / 1000) * win_ms;
        return (n == 0) ? 1 : n;
    endfunction

endpackage

// File: rtl/sync_chain.sv
// Module: sync_chain
// A multi-bit chain of synchronizing flip-flops, one independent chain per
// bit. Assumes: bits are unrelated to each other (no bus coherency), and the
// reset value of every stage is zero.
module sync_chain #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);

    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // First stage: capture the asynchronous inputs.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= d_async;
            end
        end else begin : g_next
            // Later stages: let metastability settle.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign q_sync = stage_q[STAGES-1];

endmodule

// File: rtl/btn_filter.sv
// Module: btn_filter
// Debounces one synchronized button level. A new level is accepted only after
// the input has disagreed with the held level on WINDOW consecutive edges.
// Assumes: btn_sync is already synchronous to clk.
module btn_filter #(
    parameter int unsigned WINDOW = 40000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic btn_sync,
    output logic level
);

    localparam int unsigned CNT_W = $clog2(WINDOW + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WINDOW - 1);

    logic [CNT_W-1:0] run_cnt;
    logic             differs;

    assign differs = (btn_sync != level);

    // Count how long the input has disagreed, and adopt it at the end of the window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt <= '0;
            level   <= 1'b0;
        end else if (!differs) begin
            run_cnt <= '0;
        end else if (run_cnt == LAST) begin
            run_cnt <= '0;
            level   <= btn_sync;
        end else begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/step_pulse.sv
// Module: step_pulse
// Turns the debounced level into a one-clock step pulse, and chooses between
// that pulse and a constant enable depending on the mode.
// Assumes: level and mode are synchronous to clk.
module step_pulse
    import step_en_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  level,
    input  mode_e mode,
    output logic  enable
);

    logic level_d;
    logic rise;

    assign rise = level & ~level_d;

    // Remember the previous debounced level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) level_d <= 1'b0;
        else        level_d <= level;
    end

    // Registered enable: constant in run mode, the edge pulse in step mode.
    always_ff @(posedge clk) begin
        if (!rst_n)                enable <= 1'b0;
        else if (mode == MODE_RUN) enable <= 1'b1;
        else                       enable <= rise;
    end

endmodule

// File: rtl/step_enable_gen.sv
// Module: step_enable_gen (top)
// Run/single-step clock-enable generator for a free-running system clock.
// Assumes: clk never stops; btn_raw and mode_run are asynchronous and slow.
module step_enable_gen
    import step_en_pkg::*;
#(
    parameter int unsigned CLK_HZ      = 2_000_000,
    parameter int unsigned WINDOW_MS   = 20,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic btn_raw,
    input  logic mode_run,
    output logic cpu_en,
    output logic btn_level
);

    localparam int unsigned DB_CYCLES = window_cycles(CLK_HZ, WINDOW_MS);

    logic [1:0] raw_vec;
    logic [1:0] sync_vec;
    logic       btn_sync;
    logic       run_sync;

    assign raw_vec  = {mode_run, btn_raw};
    assign btn_sync = sync_vec[0];
    assign run_sync = sync_vec[1];

    sync_chain #(
        .WIDTH  (2),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (raw_vec),
        .q_sync  (sync_vec)
    );

    btn_filter #(
        .WINDOW (DB_CYCLES)
    ) u_filter (
        .clk      (clk),
        .rst_n    (rst_n),
        .btn_sync (btn_sync),
        .level    (btn_level)
    );

    step_pulse u_pulse (
        .clk    (clk),
        .rst_n  (rst_n),
        .level  (btn_level),
        .mode   (mode_e'(run_sync)),
        .enable (cpu_en)
    );

endmodule

// File: rtl/step_enable_chk.sv
// Module: step_enable_chk
// Property checker bound into step_enable_gen.
// Assumes: reset is held for at least one edge before checks matter.
module step_enable_chk #(
    parameter int unsigned DB = 40000
) (
    input logic clk,
    input logic rst_n,
    input logic btn_sync,
    input logic run_sync,
    input logic btn_level,
    input logic cpu_en
);

    localparam int unsigned W = $clog2(DB + 1);
    localparam logic [W-1:0] LIM = W'(DB - 1);

    logic [W-1:0] mism_len;

    // Independent length of the current disagreement between input and level.
    always_ff @(posedge clk) begin
        if (!rst_n || (btn_sync == btn_level) || (mism_len == LIM)) mism_len <= '0;
        else                                                         mism_len <= mism_len + 1'b1;
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (!cpu_en && !btn_level));                                   // R1

    AST_LEVEL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (btn_sync != btn_level && mism_len != LIM) |=> $stable(btn_level));    // R3

    AST_LEVEL_ADOPTS: assert property (@(posedge clk) disable iff (!rst_n)
        (btn_sync != btn_level && mism_len == LIM) |=> (btn_level == $past(btn_sync))); // R3

    AST_STEP_ONE_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_en && !run_sync) |=> !cpu_en);                                    // R5

    AST_RUN_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        run_sync |=> cpu_en);                                                  // R7

endmodule

bind step_enable_gen step_enable_chk #(.DB(DB_CYCLES)) u_step_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .btn_sync  (btn_sync),
    .run_sync  (run_sync),
    .btn_level (btn_level),
    .cpu_en    (cpu_en)
);

// File: tb/test_step_enable_gen.sv
module test_step_enable_gen;

    localparam int unsigned HZ = 1000;
    localparam int unsigned MS = 8;
    localparam int DB = 8;   // HZ/1000*MS

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic btn_raw = 1'b0;
    logic mode_run = 1'b0;
    logic cpu_en;
    logic btn_level;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int pulses = 0;
    string tag = "R1";

    always #4 clk = ~clk;

    step_enable_gen #(.CLK_HZ(HZ), .WINDOW_MS(MS)) i_step_enable_gen (
        .clk(clk), .rst_n(rst_n), .btn_raw(btn_raw), .mode_run(mode_run),
        .cpu_en(cpu_en), .btn_level(btn_level)
    );

    // Behavioural reference model.
    bit b_q[$] = '{1'b0, 1'b0};
    bit m_q[$] = '{1'b0, 1'b0};
    int m_cnt = 0;
    bit m_lvl = 0, m_prev = 0, m_en = 0;

    always @(posedge clk) begin
        bit bs, ms;
        if (!rst_n) begin
            m_en = 0; m_lvl = 0; m_prev = 0; m_cnt = 0;
            b_q = '{1'b0, 1'b0}; m_q = '{1'b0, 1'b0};
        end else begin
            bs = b_q[0];
            ms = m_q[0];
            m_en = ms || (m_lvl && !m_prev);
            m_prev = m_lvl;
            if (bs == m_lvl) m_cnt = 0;
            else if (m_cnt == DB - 1) begin m_lvl = bs; m_cnt = 0; end
            else m_cnt++;
            void'(b_q.pop_front()); b_q.push_back(btn_raw);
            void'(m_q.pop_front()); m_q.push_back(mode_run);
        end
    end

    task automatic check(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", req, what, act, exp, cycles);
        end
    endtask

    // Per-cycle comparison with the model, away from the active edge.
    always @(negedge clk) begin
        cycles++;
        if (cpu_en) pulses++;
        check(tag, cpu_en, m_en, "cpu_en vs model");
        check(tag, btn_level, m_lvl, "btn_level vs model");
    end

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic press(input int hold);
        btn_raw = 1'b1;
        wait_cyc(hold);
        btn_raw = 1'b0;
        wait_cyc(DB + 6);
    endtask

    initial begin
        int lat;
        // R1: reset with inputs active
        mode_run = 1'b1; btn_raw = 1'b1;
        wait_cyc(5);
        check("R1", cpu_en, 0, "cpu_en in reset");
        check("R1", btn_level, 0, "btn_level in reset");
        mode_run = 1'b0; btn_raw = 1'b0;
        wait_cyc(3);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", cpu_en, 0, "cpu_en first cycle after reset");

        // R9: idle in step mode
        tag = "R9"; pulses = 0;
        wait_cyc(200);
        check("R9", pulses, 0, "pulses with no press");

        // R2: mode latency
        tag = "R2";
        mode_run = 1'b1;
        @(negedge clk); check("R2", cpu_en, 0, "cpu_en 1 edge after mode");
        @(negedge clk); check("R2", cpu_en, 0, "cpu_en 2 edges after mode");
        @(negedge clk); check("R2", cpu_en, 1, "cpu_en 3 edges after mode");

        // R7: steady in run mode
        tag = "R7"; pulses = 0;
        wait_cyc(50);
        check("R7", pulses, 50, "enabled cycles in run mode");

        // R8: press completes during run, then back to step: no pulse
        tag = "R8";
        btn_raw = 1'b1;
        wait_cyc(DB + 6);
        mode_run = 1'b0;
        wait_cyc(4);
        pulses = 0;
        wait_cyc(20);
        btn_raw = 1'b0;
        wait_cyc(DB + 6);
        check("R8", pulses, 0, "pulses after press held over run->step");

        // R3: debounce latency of a clean press; R5 one pulse
        tag = "R3"; pulses = 0;
        btn_raw = 1'b1;
        lat = 0;
        while (!btn_level && lat < 100) begin @(negedge clk); lat++; end
        check("R3", lat, DB + 2, "edges from raw press to btn_level");
        check("R5", cpu_en, 0, "cpu_en same cycle as level rise");
        @(negedge clk);
        check("R5", cpu_en, 1, "cpu_en one cycle after level rise");
        @(negedge clk);
        check("R5", cpu_en, 0, "cpu_en width one cycle");

        // R6: long hold and release add nothing
        tag = "R6";
        wait_cyc(60);
        check("R6", pulses, 1, "pulses while held");
        btn_raw = 1'b0;
        wait_cyc(DB + 6);
        check("R6", btn_level, 0, "level after release");
        check("R6", pulses, 1, "pulses after release");

        // R4: bounce one clock short of the window
        tag = "R4"; pulses = 0;
        for (int k = 0; k < 4; k++) begin
            btn_raw = 1'b1; wait_cyc(DB - 1);
            check("R4", btn_level, 0, "level during short bounce");
            btn_raw = 1'b0; wait_cyc(3);
        end
        wait_cyc(DB + 4);
        check("R4", pulses, 0, "pulses from short bounces");

        // R5: several presses, several pulses
        tag = "R5"; pulses = 0;
        for (int k = 0; k < 3; k++) press(DB + 10);
        check("R5", pulses, 3, "pulses for three presses");

        // R8: step to run while pressed gives only steady enable
        tag = "R8";
        btn_raw = 1'b1;
        wait_cyc(DB + 4);
        mode_run = 1'b1;
        wait_cyc(3);
        pulses = 0;
        wait_cyc(30);
        check("R8", pulses, 30, "steady enable after step->run");
        btn_raw = 1'b0;
        mode_run = 1'b0;
        wait_cyc(DB + 8);
        pulses = 0;
        wait_cyc(20);
        check("R8", pulses, 0, "no stray pulse after return to step");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        wait_cyc(150000);
        errors++;
        $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, 150000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule